// File: doc/BRIEF.md
# NAND Page Chunk Hamming Code Engine

This block builds the 22-bit single-error-correcting, double-error-detecting code that guards each 256-byte (2048-bit) chunk of a NAND page. Data arrives one byte per clock with a valid qualifier and a start-of-chunk marker. When the last byte of a chunk is taken, the block presents the code it computed over the chunk and raises a one-cycle done strobe.

The code has two parts. Line parity uses two bits per bit of the 8-bit byte index: one bit covers the bytes whose index bit is set, the other covers the bytes where that bit is clear. Each bit is the XOR of all eight bits of the bytes it covers. Column parity uses two bits per bit of the 3-bit position within a byte, taken over all 256 bytes. In check mode the block XORs the freshly computed code with a stored code and classifies the result. For a single flipped data bit it also reports the byte offset and the bit position, so that firmware can correct the buffer.

Top module: `nand_ecc_engine`

## Requirements
- R1: Code bits [15:0] are line parity. For index bit k (0..7), bit 2k+1 is the XOR of every data bit in bytes whose offset has bit k equal to 1, and bit 2k is the XOR of every data bit in bytes whose offset has bit k equal to 0.
- R2: Code bits [21:16] are column parity. For position bit j (0..2), bit 16+2j+1 is the XOR, across all 256 bytes, of the data bits whose position within the byte has bit j equal to 1, and bit 16+2j is the XOR of the data bits whose position has bit j equal to 0.
- R3: `out_done` is high for exactly the one cycle that follows the clock edge at which the 256th byte is accepted. `out_code`, `out_status`, `err_byte` and `err_bit` change only at that edge and hold their values until the next chunk completes.
- R4: A byte accepted with `in_sop` high is taken as byte 0 of a new chunk. Any partial chunk is discarded and no done strobe is raised for it.
- R5: Cycles with `in_valid` low neither advance the byte count nor change the code.
- R6: In check mode (`check_mode`=1, sampled with `stored_code` at the edge where the last byte is accepted), a zero syndrome (stored XOR computed) gives `out_status`=0 (clean).
- R7: A syndrome in which each of the 11 bit pairs has exactly one bit set gives `out_status`=1 (correctable data error). `err_byte` bit k is syndrome bit 2k+1, and `err_bit` bit j is syndrome bit 16+2j+1.
- R8: A syndrome with exactly one bit set gives `out_status`=2 (error in the stored code).
- R9: Any other non-zero syndrome, such as one caused by two flipped data bits, gives `out_status`=3 (uncorrectable).
- R10: In generate mode (`check_mode`=0), `out_status` is 0. In every case other than status 1, `err_byte` and `err_bit` are 0. In both modes `out_code` carries the code computed over the data that was received.
- R11: After reset, `out_done`=0, `out_code`=0, `out_status`=0 and the location outputs are 0.
- R12: After a chunk completes, the next accepted byte starts a new chunk at offset 0 even if `in_sop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_sop | input | 1 | Accepted byte is offset 0 of a new chunk |
| in_data | input | 8 | Data byte |
| check_mode | input | 1 | 1 = compare against `stored_code`, 0 = generate only |
| stored_code | input | 22 | Code read back from the spare area |
| out_done | output | 1 | One-cycle strobe when a chunk result is ready |
| out_code | output | 22 | Code computed over the received chunk |
| out_status | output | 2 | 0 clean, 1 data fix, 2 code bit error, 3 uncorrectable |
| err_byte | output | 8 | Offset of the flipped byte (status 1) |
| err_bit | output | 3 | Position of the flipped bit (status 1) |

## Verification
The assertions assume that `in_sop` is only raised together with `in_valid`, and that the inputs are never unknown once reset has been released. The result logic samples `check_mode` and `stored_code` only at the edge where the final byte is accepted, so the checks also assume both are settled in that cycle. The stimulus meets this by setting the mode and the stored code before the first byte and holding them for the whole chunk. It drives `in_sop` only in cycles where `in_valid` is high, and it keeps every input at a defined level from reset onward.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   typedef enum logic [1:0] {
      ECC_CLEAN    = 2'd0,
      ECC_DATA_FIX = 2'd1,
      ECC_CODE_HIT = 2'd2,
      ECC_FATAL    = 2'd3
   } ecc_status_e;

endpackage

// File: rtl/ecc_contrib.sv
module ecc_contrib #(
   parameter  int IDX_W  = 8,
   parameter  int DATA_W = 8,
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int LINE_W = 2 * IDX_W,
   localparam int CODE_W = LINE_W + 2 * BIT_W
) (
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W-1:0] contrib
);

   function automatic logic [DATA_W-1:0] sel_mask(input int j);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int p = 0; p < DATA_W; p++) begin
         if (((p >> j) & 1) == 1) m[p] = 1'b1;
      end
      return m;
   endfunction

   logic byte_par;
   assign byte_par = ^data;

   for (genvar k = 0; k < IDX_W; k++) begin : g_line
      assign contrib[2*k+1] = byte_par &  byte_idx[k];
      assign contrib[2*k]   = byte_par & ~byte_idx[k];
   end

   for (genvar j = 0; j < BIT_W; j++) begin : g_col
      localparam logic [DATA_W-1:0] HI_MASK = sel_mask(j);
      assign contrib[LINE_W+2*j+1] = ^(data &  HI_MASK);
      assign contrib[LINE_W+2*j]   = ^(data & ~HI_MASK);
   end

endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode #(
   parameter  int IDX_W  = 8,
   parameter  int DATA_W = 8,
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int LINE_W = 2 * IDX_W,
   localparam int PAIRS  = IDX_W + BIT_W,
   localparam int CODE_W = 2 * PAIRS
) (
   input  logic [CODE_W-1:0]        syndrome,
   output ecc_pkg::ecc_status_e     status,
   output logic [IDX_W-1:0]         loc_byte,
   output logic [BIT_W-1:0]         loc_bit
);
   import ecc_pkg::*;

   logic [PAIRS-1:0] pair_split;
   logic             syn_zero;
   logic             syn_single;
   logic             all_split;

   for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      assign pair_split[i] = syndrome[2*i] ^ syndrome[2*i+1];
   end

   assign syn_zero   = (syndrome == '0);
   assign syn_single = !syn_zero && ((syndrome & (syndrome - 1'b1)) == '0);
   assign all_split  = &pair_split;

   always_comb begin
      if (syn_zero)        status = ECC_CLEAN;
      else if (all_split)  status = ECC_DATA_FIX;
      else if (syn_single) status = ECC_CODE_HIT;
      else                 status = ECC_FATAL;
   end

   for (genvar k = 0; k < IDX_W; k++) begin : g_loc_byte
      assign loc_byte[k] = all_split & syndrome[2*k+1];
   end
   for (genvar j = 0; j < BIT_W; j++) begin : g_loc_bit
      assign loc_bit[j] = all_split & syndrome[LINE_W+2*j+1];
   end

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine #(
   parameter  int IDX_W  = 8,
   parameter  int DATA_W = 8,
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int CODE_W = 2 * IDX_W + 2 * BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              check_mode,
   input  logic [CODE_W-1:0] stored_code,
   output logic              out_done,
   output logic [CODE_W-1:0] out_code,
   output logic [1:0]        out_status,
   output logic [IDX_W-1:0]  err_byte,
   output logic [BIT_W-1:0]  err_bit
);
   import ecc_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = '1;

   logic [IDX_W-1:0]  byte_cnt;
   logic [CODE_W-1:0] acc_q;
   logic [IDX_W-1:0]  eff_idx;
   logic [CODE_W-1:0] base_acc;
   logic [CODE_W-1:0] contrib;
   logic [CODE_W-1:0] next_acc;
   logic [CODE_W-1:0] syndrome;
   logic              last_byte;
   ecc_status_e       dec_status;
   logic [IDX_W-1:0]  dec_byte;
   logic [BIT_W-1:0]  dec_bit;

   assign eff_idx   = in_sop ? '0 : byte_cnt;
   assign base_acc  = in_sop ? '0 : acc_q;
   assign next_acc  = base_acc ^ contrib;
   assign last_byte = in_valid && (eff_idx == LAST_IDX);
   assign syndrome  = next_acc ^ stored_code;

   ecc_contrib #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_contrib (
      .byte_idx (eff_idx),
      .data     (in_data),
      .contrib  (contrib)
   );

   ecc_syndrome_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_decode (
      .syndrome (syndrome),
      .status   (dec_status),
      .loc_byte (dec_byte),
      .loc_bit  (dec_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
         acc_q    <= '0;
      end else if (in_valid) begin
         if (last_byte) begin
            byte_cnt <= '0;
            acc_q    <= '0;
         end else begin
            byte_cnt <= eff_idx + 1'b1;
            acc_q    <= next_acc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_done   <= 1'b0;
         out_code   <= '0;
         out_status <= ECC_CLEAN;
         err_byte   <= '0;
         err_bit    <= '0;
      end else begin
         out_done <= last_byte;
         if (last_byte) begin
            out_code <= next_acc;
            if (check_mode) begin
               out_status <= dec_status;
               err_byte   <= dec_byte;
               err_bit    <= dec_bit;
            end else begin
               out_status <= ECC_CLEAN;
               err_byte   <= '0;
               err_bit    <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk #(
   parameter  int IDX_W  = 8,
   parameter  int DATA_W = 8,
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int CODE_W = 2 * IDX_W + 2 * BIT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sop,
   input logic              out_done,
   input logic [CODE_W-1:0] out_code,
   input logic [1:0]        out_status,
   input logic [IDX_W-1:0]  err_byte,
   input logic [BIT_W-1:0]  err_bit,
   input logic [IDX_W-1:0]  byte_cnt
);
   localparam logic [IDX_W-1:0] LAST_IDX = '1;

   initial begin
      param_shape_chk: assert (IDX_W >= 2 && DATA_W >= 2 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("index width and byte width must be >= 2, byte width a power of two");
   end

   // R3
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   // R3
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sop && byte_cnt == LAST_IDX) |=> out_done);

   // R3
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> ($stable(out_code) && $stable(out_status)));

   // R4
   sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |=> (byte_cnt == 1));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(byte_cnt));

   // R10
   loc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_status != 2'd1) |-> (err_byte == '0 && err_bit == '0));

endmodule

bind nand_ecc_engine nand_ecc_engine_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sop     (in_sop),
   .out_done   (out_done),
   .out_code   (out_code),
   .out_status (out_status),
   .err_byte   (err_byte),
   .err_bit    (err_bit),
   .byte_cnt   (byte_cnt)
);

// File: tb/nand_ecc_engine_tb.sv
module nand_ecc_engine_tb;

   typedef struct packed {
      logic [7:0]  seed;
      logic        chk;
      logic [1:0]  nflip;
      logic [7:0]  fb0;
      logic [2:0]  fp0;
      logic [7:0]  fb1;
      logic [2:0]  fp1;
      logic [21:0] cmask;
      logic [1:0]  exp_st;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{8'h11, 1'b0, 2'd0, 8'd0,   3'd0, 8'd0,  3'd0, 22'h0,      2'd0},
      '{8'h00, 1'b0, 2'd0, 8'd0,   3'd0, 8'd0,  3'd0, 22'h0,      2'd0},
      '{8'h2C, 1'b1, 2'd0, 8'd0,   3'd0, 8'd0,  3'd0, 22'h0,      2'd0},
      '{8'h3D, 1'b1, 2'd1, 8'hA5,  3'd6, 8'd0,  3'd0, 22'h0,      2'd1},
      '{8'h47, 1'b1, 2'd1, 8'h00,  3'd0, 8'd0,  3'd0, 22'h0,      2'd1},
      '{8'h58, 1'b1, 2'd1, 8'hFF,  3'd7, 8'd0,  3'd0, 22'h0,      2'd1},
      '{8'h69, 1'b1, 2'd0, 8'd0,   3'd0, 8'd0,  3'd0, 22'h000400, 2'd2},
      '{8'h7A, 1'b1, 2'd0, 8'd0,   3'd0, 8'd0,  3'd0, 22'h200000, 2'd2},
      '{8'h8B, 1'b1, 2'd2, 8'd3,   3'd1, 8'd77, 3'd4, 22'h0,      2'd3},
      '{8'h9C, 1'b1, 2'd0, 8'd0,   3'd0, 8'd0,  3'd0, 22'h000003, 2'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic [7:0]  in_data = '0;
   logic        check_mode = 1'b0;
   logic [21:0] stored_code = '0;
   logic        out_done;
   logic [21:0] out_code;
   logic [1:0]  out_status;
   logic [7:0]  err_byte;
   logic [2:0]  err_bit;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   logic [7:0] dbuf [256];

   always #2 clk = ~clk;

   nand_ecc_engine u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sop (in_sop),
      .in_data (in_data), .check_mode (check_mode), .stored_code (stored_code),
      .out_done (out_done), .out_code (out_code), .out_status (out_status),
      .err_byte (err_byte), .err_bit (err_bit)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic fill(input logic [7:0] seed);
      for (int b = 0; b < 256; b++)
         dbuf[b] = 8'((b * (seed + 3)) ^ (seed << 1) ^ (b >> 2));
   endtask

   function automatic logic [21:0] ref_code();
      logic [21:0] c = '0;
      for (int b = 0; b < 256; b++)
         for (int p = 0; p < 8; p++)
            if (dbuf[b][p]) begin
               for (int k = 0; k < 8; k++) c[2*k + ((b >> k) & 1)] ^= 1'b1;
               for (int j = 0; j < 3; j++) c[16 + 2*j + ((p >> j) & 1)] ^= 1'b1;
            end
      return c;
   endfunction

   // Streams dbuf; leaves the bench at the negedge where out_done must be high.
   task automatic stream(input bit use_sop, input bit chk, input logic [21:0] stored,
                         input bit gaps, output bit early);
      early = 1'b0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (out_done) early = 1'b1;
         if (gaps && (i % 37) == 5) begin
            in_valid = 1'b0;
            in_sop   = 1'b0;
            @(negedge clk);
            if (out_done) early = 1'b1;
         end
         in_valid    = 1'b1;
         in_sop      = use_sop && (i == 0);
         in_data     = dbuf[i];
         check_mode  = chk;
         stored_code = stored;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
   endtask

   task automatic check_result(input string req, input logic [21:0] ecode, input logic [1:0] est,
                               input logic [7:0] eb, input logic [2:0] ep, input bit early);
      check(out_done == 1'b1, "R3 done strobe", 32'(out_done), 32'd1);
      check(!early, "R3 no early done", 32'(early), 32'd0);
      check(out_code == ecode, "R1/R2 code", 32'(out_code), 32'(ecode));
      check(out_status == est, req, 32'(out_status), 32'(est));
      check(err_byte == eb && err_bit == ep, (est == 2'd1) ? "R7 location" : "R10 location zero",
            {21'(err_byte), err_bit}, {21'(eb), ep});
      @(negedge clk);
      check(out_done == 1'b0 && out_code == ecode, "R3 single pulse and hold",
            {10'(out_done), out_code}, {10'd0, ecode});
   endtask

   initial begin
      logic [21:0] orig;
      logic [21:0] ecode;
      bit          early;
      string       tag;
      vec_t        v;

      repeat (3) @(negedge clk);
      // R11 reset state
      check(out_done == 0 && out_code == 0 && out_status == 0 && err_byte == 0 && err_bit == 0,
            "R11 reset outputs", {out_done, out_code, out_status, err_byte}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_done == 0 && out_code == 0, "R11 after release", {out_done, out_code}, 32'd0);

      for (int n = 0; n < NVEC; n++) begin
         v = VECS[n];
         fill(v.seed);
         orig = ref_code();
         if (v.nflip >= 1) dbuf[v.fb0][v.fp0] = ~dbuf[v.fb0][v.fp0];
         if (v.nflip == 2) dbuf[v.fb1][v.fp1] = ~dbuf[v.fb1][v.fp1];
         ecode = ref_code();
         case (v.exp_st)
            2'd1:    tag = "R7 status data fix";
            2'd2:    tag = "R8 status code hit";
            2'd3:    tag = "R9 status uncorrectable";
            default: tag = v.chk ? "R6 status clean" : "R10 generate status";
         endcase
         stream(1'b1, v.chk, orig ^ v.cmask, 1'b0, early);
         check_result(tag, ecode, v.exp_st,
                      (v.exp_st == 2'd1) ? v.fb0 : 8'd0,
                      (v.exp_st == 2'd1) ? v.fp0 : 3'd0, early);
      end

      // R5: idle cycles inside the chunk
      fill(8'h5A);
      ecode = ref_code();
      stream(1'b1, 1'b1, ecode, 1'b1, early);
      check_result("R5 gaps clean", ecode, 2'd0, 8'd0, 3'd0, early);

      // R4: partial chunk then restart with sop
      fill(8'hE1);
      early = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (i == 0);
         in_data  = 8'(i * 13 + 1);
      end
      fill(8'h23);
      ecode = ref_code();
      stream(1'b1, 1'b0, 22'd0, 1'b0, early);
      check_result("R4 restart status", ecode, 2'd0, 8'd0, 3'd0, early);

      // R12: second chunk without sop
      fill(8'h34);
      stream(1'b1, 1'b0, 22'd0, 1'b0, early);
      @(negedge clk);
      fill(8'h45);
      ecode = ref_code();
      stream(1'b0, 1'b1, ecode ^ 22'h000010, 1'b0, early);
      check(out_code == ecode, "R12 code without sop", 32'(out_code), 32'(ecode));
      check(out_status == 2'd2, "R12 R8 status", 32'(out_status), 32'd2);

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule